// File: doc/BRIEF.md
# Vectored Level-Sensitive Interrupt Controller

This block gathers up to 31 level-sensitive interrupt lines plus a small group of non-maskable lines. It gives the processor core one interrupt request wire, an 8-bit vector and a separate non-maskable request. Software sees five 32-bit word registers through a simple read/write strobe port. The only writable register is the enable mask. The other four are read-only: the raw line levels, the masked pending set, the non-maskable status and an exception status word that always reads zero.

The vector is not priority encoded. When exactly one enabled line is active, the vector names that line directly. When two or more enabled lines are active together, the vector is a shared code, and software reads the masked register to decide which one to serve first. Every external line passes through a two-flop synchronizer. The outputs are registered.

Top module: `irqvec_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), the mask is zero, irq_req, irq_vec and nmi_req are all 0, and a read of every offset returns 0.
- R2: A write with bus_addr[4:2] = 0 (offset 0x00) loads the mask from bus_wdata[30:0]. Reading offset 0x00 returns the mask, with bit 31 always reading 0.
- R3: A write to any offset whose bus_addr[4:2] is not 0 leaves the mask unchanged, and so leaves the outputs unchanged.
- R4: Reading offset 0x04 (bus_addr[4:2] = 1) returns the raw line levels: bit k is the synchronized level of irq_in[k].
- R5: Reading offset 0x08 (bus_addr[4:2] = 2) returns the raw levels ANDed with the mask.
- R6: When exactly one masked bit k is set, irq_req is 1 and irq_vec is 0x31 + k.
- R7: When two or more masked bits are set, irq_req is 1 and irq_vec is 0x30.
- R8: When no masked bit is set, irq_req is 0 and irq_vec is 0x00.
- R9: Reading offset 0x0C (bus_addr[4:2] = 3) returns the non-maskable status, where bit j is the synchronized level of nmi_in[j]. nmi_req is 1 whenever any status bit is set, whatever the mask holds.
- R10: Offset 0x10 (exception status) reads 0. Offsets 0x14, 0x18 and 0x1C read 0. bus_addr[1:0] is ignored.
- R11: A change on irq_in or nmi_in reaches the outputs at the third rising edge after it is applied. A mask write reaches the outputs at the second rising edge after the write strobe. Read data is registered and appears after the edge that samples bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 31 | Asynchronous level-sensitive interrupt lines |
| nmi_in | input | 2 | Asynchronous non-maskable lines |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 8 | Interrupt vector code |
| nmi_req | output | 1 | Non-maskable request to the core |

## Verification
A corrupted mask bit shows up within two cycles of the write. It appears either as a vector that names the wrong line, or as the shared code where a single line was expected, and the mask readback confirms it on the next read. A synchronizer stage that is skipped or stuck moves every output change one cycle early, or loses it entirely. The bench catches this by sampling the old value one edge before the expected update and the new value exactly at it. Miscounting a multi-source condition shows at once as 0x30 against 0x31+k.

// File: rtl/irqvec_pkg.sv
// Shared constants for the vectored interrupt controller.
// Assumes word-spaced registers decoded from a 3-bit word index.
package irqvec_pkg;
    localparam int          IDX_W      = 3;
    localparam logic [2:0]  IDX_MASK   = 3'd0;
    localparam logic [2:0]  IDX_RAW    = 3'd1;
    localparam logic [2:0]  IDX_MASKED = 3'd2;
    localparam logic [2:0]  IDX_NMI    = 3'd3;
    localparam logic [2:0]  IDX_EXC    = 3'd4;
endpackage

// File: rtl/irqvec_sync.sv
// Two-stage synchronizer, one chain per bit.
// Assumes each bit is an independent level; no multi-bit coherence is implied.
module irqvec_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q;
        logic stab_q;
        // Capture and settle one line over two edges.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_in[b];
                stab_q <= meta_q;
            end
        end
        assign sync_out[b] = stab_q;
    end
endmodule

// File: rtl/irqvec_regs.sv
// Register file: the mask register, masking of the raw levels, registered read mux.
// Assumes NUM_LINES and NUM_NMI do not exceed DATA_W. Only word index 0 is writable.
module irqvec_regs
    import irqvec_pkg::*;
#(
    parameter int NUM_LINES = 31,
    parameter int NUM_NMI   = 2,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [IDX_W-1:0]     idx,
    input  logic [NUM_LINES-1:0] wr_bits,
    input  logic [NUM_LINES-1:0] raw,
    input  logic [NUM_NMI-1:0]   nmi_stat,
    output logic [NUM_LINES-1:0] mask,
    output logic [NUM_LINES-1:0] masked,
    output logic [DATA_W-1:0]    rdata
);
    logic [NUM_LINES-1:0] mask_q;
    logic [DATA_W-1:0]    rd_next;

    // Hold the enable mask; only the mask index accepts writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_en && idx == IDX_MASK)
            mask_q <= wr_bits;
    end

    assign mask   = mask_q;
    assign masked = raw & mask_q;

    // Select the word for the addressed index, zero-extended.
    always_comb begin
        rd_next = '0;
        case (idx)
            IDX_MASK:   rd_next[NUM_LINES-1:0] = mask_q;
            IDX_RAW:    rd_next[NUM_LINES-1:0] = raw;
            IDX_MASKED: rd_next[NUM_LINES-1:0] = masked;
            IDX_NMI:    rd_next[NUM_NMI-1:0]   = nmi_stat;
            IDX_EXC:    rd_next = '0;
            default:    rd_next = '0;
        endcase
    end

    // Register read data on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_next;
    end
endmodule

// File: rtl/irqvec_encode.sv
// Vector encoder: one active source gives BASE_VEC+1+index, several give BASE_VEC,
// none gives zero with the request low. Assumes BASE_VEC+NUM_LINES fits in VEC_W.
module irqvec_encode #(
    parameter int                NUM_LINES = 31,
    parameter int                VEC_W     = 8,
    parameter logic [VEC_W-1:0]  BASE_VEC  = 'h30
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] masked,
    output logic                 irq_req,
    output logic [VEC_W-1:0]     irq_vec
);
    localparam int IX_W = $clog2(NUM_LINES);

    logic              any_set;
    logic              many_set;
    logic [IX_W-1:0]   low_idx;
    logic [VEC_W-1:0]  vec_next;

    assign any_set  = |masked;
    assign many_set = |(masked & (masked - NUM_LINES'(1)));

    // Locate the lowest set bit; only used when a single bit is set.
    always_comb begin
        low_idx = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (masked[i])
                low_idx = IX_W'(i);
        end
    end

    // Choose the vector code from the pending pattern.
    always_comb begin
        if (!any_set)
            vec_next = '0;
        else if (many_set)
            vec_next = BASE_VEC;
        else
            vec_next = BASE_VEC + VEC_W'(1) + VEC_W'(low_idx);
    end

    // Register the request and vector toward the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_vec <= '0;
        end else begin
            irq_req <= any_set;
            irq_vec <= vec_next;
        end
    end
endmodule

// File: rtl/irqvec_ctrl.sv
// Top of the vectored interrupt controller: synchronizers, register file,
// vector encoder and the non-maskable request. Assumes a byte-addressed word window.
module irqvec_ctrl
    import irqvec_pkg::*;
#(
    parameter int               NUM_LINES = 31,
    parameter int               NUM_NMI   = 2,
    parameter int               DATA_W    = 32,
    parameter int               ADDR_W    = 5,
    parameter int               VEC_W     = 8,
    parameter logic [VEC_W-1:0] BASE_VEC  = 'h30
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_NMI-1:0]   nmi_in,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_req,
    output logic [VEC_W-1:0]     irq_vec,
    output logic                 nmi_req
);
    logic [NUM_LINES-1:0] raw_lvl;
    logic [NUM_NMI-1:0]   nmi_lvl;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] masked_lvl;
    logic [IDX_W-1:0]     word_idx;
    logic [1:0]           unused_addr_lo;
    logic [DATA_W-NUM_LINES-1:0] unused_wdata_hi;

    assign word_idx        = bus_addr[IDX_W+1:2];
    assign unused_addr_lo  = bus_addr[1:0];
    assign unused_wdata_hi = bus_wdata[DATA_W-1:NUM_LINES];

    irqvec_sync #(.WIDTH(NUM_LINES)) u_sync_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (raw_lvl)
    );

    irqvec_sync #(.WIDTH(NUM_NMI)) u_sync_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (nmi_in),
        .sync_out (nmi_lvl)
    );

    irqvec_regs #(
        .NUM_LINES (NUM_LINES),
        .NUM_NMI   (NUM_NMI),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .rd_en    (bus_rd),
        .idx      (word_idx),
        .wr_bits  (bus_wdata[NUM_LINES-1:0]),
        .raw      (raw_lvl),
        .nmi_stat (nmi_lvl),
        .mask     (mask_q),
        .masked   (masked_lvl),
        .rdata    (bus_rdata)
    );

    irqvec_encode #(
        .NUM_LINES (NUM_LINES),
        .VEC_W     (VEC_W),
        .BASE_VEC  (BASE_VEC)
    ) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .masked  (masked_lvl),
        .irq_req (irq_req),
        .irq_vec (irq_vec)
    );

    // Raise the non-maskable request while any status bit is set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nmi_req <= 1'b0;
        else
            nmi_req <= |nmi_lvl;
    end
endmodule

// File: rtl/irqvec_ctrl_chk.sv
// Property checker for irqvec_ctrl, attached through bind.
// Assumes it observes the top's ports and its mask register.
module irqvec_ctrl_chk #(
    parameter int               NUM_LINES = 31,
    parameter int               VEC_W     = 8,
    parameter logic [VEC_W-1:0] BASE_VEC  = 'h30
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr,
    input logic [2:0]           idx,
    input logic [NUM_LINES-1:0] wr_bits,
    input logic [NUM_LINES-1:0] mask_q,
    input logic                 irq_req,
    input logic [VEC_W-1:0]     irq_vec,
    input logic                 nmi_req
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_req && irq_vec == '0 && !nmi_req && mask_q == '0));

    // R2
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == 3'd0) |=> (mask_q == $past(wr_bits)));

    // R3
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx != 3'd0) |=> $stable(mask_q));

    // R8
    idle_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_vec == '0));

    // R6
    active_vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec >= BASE_VEC && irq_vec <= BASE_VEC + VEC_W'(NUM_LINES)));
endmodule

bind irqvec_ctrl irqvec_ctrl_chk #(
    .NUM_LINES (NUM_LINES),
    .VEC_W     (VEC_W),
    .BASE_VEC  (BASE_VEC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (bus_wr),
    .idx     (bus_addr[4:2]),
    .wr_bits (bus_wdata[NUM_LINES-1:0]),
    .mask_q  (mask_q),
    .irq_req (irq_req),
    .irq_vec (irq_vec),
    .nmi_req (nmi_req)
);

// File: tb/irqvec_ctrl_bench.sv
module irqvec_ctrl_bench;
    localparam int NL = 31;
    localparam int NN = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] irq_in = '0;
    logic [NN-1:0] nmi_in = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_req;
    logic [7:0]    irq_vec;
    logic          nmi_req;

    irqvec_ctrl u_irqvec_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .irq_vec(irq_vec), .nmi_req(nmi_req)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit          is_read;
        logic        req;
        logic [7:0]  vec;
        logic        nmi;
        logic [31:0] rd;
        string       tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    logic [NL-1:0] m_mask = '0;
    logic [NL-1:0] m_raw = '0;
    logic [NN-1:0] m_nmi = '0;

    // Monitor: pop one expected item per falling edge and compare.
    always @(negedge clk) begin
        exp_t e;
        if (q.size() > 0) begin
            e = q.pop_front();
            total++;
            if (e.is_read) begin
                if (bus_rdata !== e.rd) begin
                    bad++;
                    $display("FAIL %s rdata actual=%h expected=%h", e.tag, bus_rdata, e.rd);
                end
            end else if (irq_req !== e.req || irq_vec !== e.vec || nmi_req !== e.nmi) begin
                bad++;
                $display("FAIL %s req/vec/nmi actual=%b/%h/%b expected=%b/%h/%b",
                         e.tag, irq_req, irq_vec, nmi_req, e.req, e.vec, e.nmi);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push_vals(input logic req, input logic [7:0] vec, input logic nmi, input string tag);
        exp_t e;
        e.is_read = 1'b0; e.req = req; e.vec = vec; e.nmi = nmi; e.rd = '0; e.tag = tag;
        q.push_back(e);
    endtask

    // Expected outputs from the model state, per R6/R7/R8/R9.
    task automatic push_out(input string tag);
        logic [NL-1:0] m;
        int cnt;
        int k;
        m = m_raw & m_mask;
        cnt = 0;
        k = 0;
        for (int i = 0; i < NL; i++) if (m[i]) begin cnt++; k = i; end
        if (cnt == 0)      push_vals(1'b0, 8'h00, |m_nmi, tag);
        else if (cnt > 1)  push_vals(1'b1, 8'h30, |m_nmi, tag);
        else               push_vals(1'b1, 8'h31 + 8'(k), |m_nmi, tag);
    endtask

    task automatic read_chk(input logic [4:0] addr, input logic [31:0] expv, input string tag);
        exp_t e;
        bus_addr = addr; bus_rd = 1'b1;
        tick();
        bus_rd = 1'b0;
        e.is_read = 1'b1; e.req = 1'b0; e.vec = '0; e.nmi = 1'b0; e.rd = expv; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic write_reg(input logic [4:0] addr, input logic [31:0] data);
        bus_addr = addr; bus_wdata = data; bus_wr = 1'b1;
        if (addr[4:2] == 3'd0) m_mask = data[NL-1:0];
        tick();
        bus_wr = 1'b0;
        tick();
    endtask

    task automatic set_lines(input logic [NL-1:0] lv, input logic [NN-1:0] nv);
        irq_in = lv; nmi_in = nv; m_raw = lv; m_nmi = nv;
        repeat (3) tick();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Driver
    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        push_out("R1 reset outputs");
        tick();
        for (int a = 0; a < 8; a++) read_chk(5'(a * 4), 32'h0, "R1 reset read");

        // R4 raw levels, R8 nothing enabled
        set_lines(31'h2000_0401, 2'b00);
        read_chk(5'h04, {1'b0, m_raw}, "R4 raw read");
        push_out("R8 masked none");
        tick();

        // R2 mask write and readback, bit 31 reads 0
        write_reg(5'h00, 32'hFFFF_FFFF);
        read_chk(5'h00, 32'h7FFF_FFFF, "R2 mask readback");
        push_out("R7 several enabled");
        tick();

        // R5 masked read
        write_reg(5'h00, 32'h0000_0401);
        read_chk(5'h08, {1'b0, m_raw & m_mask}, "R5 masked read");
        push_out("R7 two enabled");
        tick();

        // R6 single sources at low, mid and top positions
        write_reg(5'h00, 32'h7FFF_FFFF);
        set_lines(31'h0000_0001, 2'b00); push_out("R6 line 0");  tick();
        set_lines(31'h0000_0020, 2'b00); push_out("R6 line 5");  tick();
        set_lines(31'h4000_0000, 2'b00); push_out("R6 line 30"); tick();
        set_lines(31'h4000_0001, 2'b00); push_out("R7 ends");    tick();

        // R6 single enabled among several raw
        set_lines(31'h0000_0208, 2'b00);
        write_reg(5'h00, 32'h0000_0200);
        push_out("R6 one of two enabled");
        tick();
        read_chk(5'h08, 32'h0000_0200, "R5 partial mask");

        // R3 writes elsewhere ignored (bus_addr[1:0] nonzero too)
        write_reg(5'h08, 32'h0000_0000);
        write_reg(5'h05, 32'h0000_0000);
        write_reg(5'h10, 32'h0000_0000);
        read_chk(5'h00, 32'h0000_0200, "R3 mask kept");
        push_out("R3 outputs kept");
        tick();

        // R9 non-maskable path ignores mask
        write_reg(5'h00, 32'h0);
        set_lines(m_raw, 2'b10);
        push_out("R9 nmi set");
        tick();
        read_chk(5'h0C, 32'h0000_0002, "R9 nmi status");
        set_lines(m_raw, 2'b00);
        push_out("R9 nmi clear");
        tick();

        // R10 exception status and unused offsets, low address bits ignored
        read_chk(5'h10, 32'h0, "R10 exception word");
        read_chk(5'h14, 32'h0, "R10 offset 0x14");
        read_chk(5'h1C, 32'h0, "R10 offset 0x1C");
        read_chk(5'h07, {1'b0, m_raw}, "R10 low bits ignored");

        // R11 input latency: old value one edge early, new at the third edge
        write_reg(5'h00, 32'h7FFF_FFFF);
        irq_in = 31'h0000_0004;
        tick(); tick();
        push_out("R11 input not yet seen");
        m_raw = 31'h0000_0004;
        tick();
        push_out("R11 input seen");
        tick();

        // R11 mask latency: old after one edge, new after two
        bus_addr = 5'h00; bus_wdata = 32'h0; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
        push_out("R11 mask not yet applied");
        m_mask = '0;
        tick();
        push_out("R11 mask applied");
        tick();
        tick();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule